// File: doc/BRIEF.md
# Reference-Clock Interval Counter

This block measures the time from a rising edge on a start event line to a later rising edge on a stop event line. It counts whole periods of its own reference clock. Neither event line has any phase relation to that clock. Each line therefore passes through a synchroniser, and an edge detector then turns its rising edge into a one-cycle event. A small phase controller opens a counting window on the start event and closes it on the stop event. A saturating binary counter advances once per reference cycle while the window is open.

When the window closes, the count is copied into a result register, an overflow bit is stored with it, and a done line pulses for one cycle. The block then holds its result and ignores further events until a re-arm pulse returns it to the waiting state. The measured time is the result multiplied by the reference period. Because both event lines are quantised to reference edges, one measurement can be off by up to two periods, for example 8 ns with a 250 MHz reference. The longest interval that can be measured is set only by the counter width.

Top module: `interval_meter`

## Requirements
- R1: After reset, `meas_count` is 0, `meas_ovf` is 0, `done` is 0, and the block waits for a start edge.
- R2: Suppose the start line is first sampled high at reference edge j and the stop line is first sampled high at edge j+G, with G at least 1. Then the stored result is G, provided G does not exceed 2^CNT_W-1.
- R3: `done` is high for exactly one cycle per measurement. `meas_count` and `meas_ovf` take their new values in the same cycle, and they keep those values until the next `done`.
- R4: A stop edge is ignored while the block waits for a start edge. This also holds when the stop edge is recognised in the same cycle as the start edge.
- R5: The counter saturates at 2^CNT_W-1. `meas_ovf` is 1 exactly when G exceeds 2^CNT_W-1; in that case `meas_count` reads 2^CNT_W-1. For G equal to 2^CNT_W-1, `meas_ovf` is 0.
- R6: After `done`, start and stop edges are ignored until `rearm` (active high, sampled at a clock edge) is seen. A `rearm` pulse is ignored while a window is open or while the block is already waiting.
- R7: Further start edges while the window is open do not restart the count.
- R8: Only rising edges count; a line held high gives a single event. An event line sampled high at edge k is acted on at edge k+2, so `done` is visible three falling edges after the stop line is driven high on a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | Asynchronous start event line |
| stop_evt | input | 1 | Asynchronous stop event line |
| rearm | input | 1 | Returns the block from holding to waiting |
| meas_count | output | CNT_W | Last measured interval in reference periods |
| meas_ovf | output | 1 | Last measurement exceeded the counter range |
| done | output | 1 | One-cycle pulse when a new result is stored |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the stop event and counter saturation. Gaps of 63 and 64 with a 6-bit counter make stop arrive just before and exactly at the saturating step. Only the longer gap may set `meas_ovf`, and both must read 63. The second pair is start and stop recognised together. Raising both lines on the same falling edge provokes this, and the bench expects a result measured only from the later, separate stop edge. A behavioural model in the bench predicts `done`, `meas_count` and `meas_ovf` on every cycle and compares all three.

// File: rtl/tim_pkg.sv
package tim_pkg;
  // Phase of a measurement as seen by the window controller.
  typedef enum logic [1:0] {
    PH_ARMED = 2'd0,
    PH_OPEN  = 2'd1,
    PH_HELD  = 2'd2
  } phase_t;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic evt_rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              prev_q;

  // The first stage samples the raw line; later stages only follow.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= evt_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign evt_rise = chain[LAST] & ~prev_q;

  // R8: a rising edge is reported for one cycle only
  a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rise |=> !evt_rise);
endmodule

// File: rtl/win_ctrl.sv
module win_ctrl
  import tim_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_rise,
  input  logic   stop_rise,
  input  logic   rearm,
  output phase_t phase,
  output logic   cnt_clear,
  output logic   cnt_step,
  output logic   capture
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d   = phase_q;
    cnt_clear = 1'b0;
    cnt_step  = 1'b0;
    capture   = 1'b0;
    case (phase_q)
      PH_ARMED: begin
        if (start_rise) begin
          phase_d   = PH_OPEN;
          cnt_clear = 1'b1;
        end
      end
      PH_OPEN: begin
        if (stop_rise) begin
          phase_d = PH_HELD;
          capture = 1'b1;
        end else begin
          cnt_step = 1'b1;
        end
      end
      PH_HELD: begin
        if (rearm) phase_d = PH_ARMED;
      end
      default: phase_d = PH_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_ARMED;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R4: a lone stop edge leaves the block waiting
  a_r4_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ARMED && stop_rise && !start_rise) |=> phase_q == PH_ARMED);
  // R6: the held phase is left only through rearm
  a_r6_hold_until_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HELD && !rearm) |=> phase_q == PH_HELD);
  // R7: another start while open keeps the window open
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OPEN && start_rise && !stop_rise) |=> phase_q == PH_OPEN);
endmodule

// File: rtl/sat_cnt.sv
module sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next_sat,
  output logic         ovf_next
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         ovf_q;

  // Next value of a saturating increment.
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + 1'b1;
  endfunction

  // Whether an increment of v would pass the top of the range.
  function automatic logic hits_top(input logic [W-1:0] v);
    return v == CNT_MAX;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (step) begin
      cnt_q <= sat_inc(cnt_q);
      ovf_q <= ovf_q | hits_top(cnt_q);
    end
  end

  assign cnt          = cnt_q;
  assign cnt_next_sat = sat_inc(cnt_q);
  assign ovf_next     = ovf_q | hits_top(cnt_q);

  // R2: each open cycle below the top adds one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R5: at the top the counter stays put and remembers the overflow
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && ovf_q));
endmodule

// File: rtl/interval_meter.sv
module interval_meter
  import tim_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             rearm,
  output logic [CNT_W-1:0] meas_count,
  output logic             meas_ovf,
  output logic             done
);
  logic             start_rise, stop_rise;
  phase_t           phase;
  logic             cnt_clear, cnt_step, capture;
  logic [CNT_W-1:0] cnt, cnt_next_sat;
  logic             ovf_next;

  logic [CNT_W-1:0] res_q;
  logic             res_ovf_q;
  logic             done_q;

  evt_sync #(.STAGES(SYNC_STAGES)) i_sync_start (
    .clk(clk), .rst_n(rst_n), .evt_async(start_evt), .evt_rise(start_rise)
  );

  evt_sync #(.STAGES(SYNC_STAGES)) i_sync_stop (
    .clk(clk), .rst_n(rst_n), .evt_async(stop_evt), .evt_rise(stop_rise)
  );

  win_ctrl i_win (
    .clk(clk), .rst_n(rst_n),
    .start_rise(start_rise), .stop_rise(stop_rise), .rearm(rearm),
    .phase(phase), .cnt_clear(cnt_clear), .cnt_step(cnt_step), .capture(capture)
  );

  sat_cnt #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n),
    .clear(cnt_clear), .step(cnt_step),
    .cnt(cnt), .cnt_next_sat(cnt_next_sat), .ovf_next(ovf_next)
  );

  // The stop cycle itself counts as one more period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_ovf_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= capture;
      if (capture) begin
        res_q     <= cnt_next_sat;
        res_ovf_q <= ovf_next;
      end
    end
  end

  assign meas_count = res_q;
  assign meas_ovf   = res_ovf_q;
  assign done       = done_q;

  // R3: done never lasts two cycles
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R3: the result only moves together with done
  a_r3_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(res_q) && $stable(res_ovf_q) && !done_q));
  // R6: a capture can only come from an open window
  a_r6_capture_open: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> phase == PH_OPEN);
  // R5: an overflowed result always reads full scale
  a_r5_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf_q |-> res_q == {CNT_W{1'b1}});
endmodule

// File: tb/test_interval_meter.sv
`timescale 1ns/1ps
module test_interval_meter;
  localparam int W    = 6;
  localparam int TOP  = (1 << W) - 1;
  localparam int WDOG = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_evt = 1'b0, stop_evt = 1'b0, rearm = 1'b0;
  logic [W-1:0] meas_count;
  logic         meas_ovf, done;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  interval_meter #(.CNT_W(W), .SYNC_STAGES(2)) i_interval_meter (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .rearm(rearm), .meas_count(meas_count), .meas_ovf(meas_ovf), .done(done)
  );

  // Behavioural model: history of sampled lines, phase as an integer.
  int m_phase = 0, m_cnt = 0;
  bit m_ovf = 0;
  int e_res = 0; bit e_ovf = 0, e_done = 0;
  bit sh[3] = '{0, 0, 0};
  bit ph[3] = '{0, 0, 0};

  always @(posedge clk) begin
    bit st, sp;
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_ovf = 0; e_res = 0; e_ovf = 0; e_done = 0;
      sh = '{0, 0, 0}; ph = '{0, 0, 0};
    end else begin
      st = sh[1] && !sh[2];
      sp = ph[1] && !ph[2];
      e_done = 0;
      if (m_phase == 0) begin
        if (st) begin m_phase = 1; m_cnt = 0; m_ovf = 0; end
      end else if (m_phase == 1) begin
        if (sp) begin
          e_res = (m_cnt + 1 > TOP) ? TOP : m_cnt + 1;
          e_ovf = m_ovf || (m_cnt == TOP);
          e_done = 1; m_phase = 2;
        end else if (m_cnt == TOP) m_ovf = 1;
        else m_cnt++;
      end else if (rearm) m_phase = 0;
      sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = start_evt;
      ph[2] = ph[1]; ph[1] = ph[0]; ph[0] = stop_evt;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > WDOG) begin
    checks++; fails++;
    $display("FAIL watchdog %s: actual cycles %0d expected below %0d", cur_req, cyc, WDOG);
    finish_run();
  end

  // Cycle compare against the model, away from the active edge.
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (done !== e_done || meas_count !== W'(e_res) || meas_ovf !== e_ovf) begin
      fails++;
      $display("FAIL %s cycle %0d: actual done=%0b cnt=%0d ovf=%0b expected done=%0b cnt=%0d ovf=%0b",
               cur_req, cyc, done, meas_count, meas_ovf, e_done, e_res, e_ovf);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Raise start, raise stop gap cycles later, drop both; returns latency of done.
  task automatic measure(int gap, output int lat, output int res, output int ovf);
    lat = -1; res = -1; ovf = -1;
    @(negedge clk) start_evt = 1'b1;
    repeat (gap) @(negedge clk);
    stop_evt = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (done && lat < 0) begin lat = i; res = meas_count; ovf = meas_ovf; end
      if (i == 4) begin start_evt = 1'b0; stop_evt = 1'b0; end
    end
  endtask

  task automatic pulse_rearm();
    @(negedge clk) rearm = 1'b1;
    @(negedge clk) rearm = 1'b0;
  endtask

  task automatic run_gap(string req, int gap);
    int lat, res, ovf;
    cur_req = req;
    measure(gap, lat, res, ovf);
    chk({req, " latency"}, lat, 3);
    chk({req, " count"}, res, (gap > TOP) ? TOP : gap);
    chk({req, " overflow"}, ovf, (gap > TOP) ? 1 : 0);
    pulse_rearm();
  endtask

  initial begin
    int lat, res, ovf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk("R1 count", meas_count, 0);
    chk("R1 ovf", meas_ovf, 0);
    chk("R1 done", done, 0);

    run_gap("R2", 5);          // R2 typical gap, R8 latency
    run_gap("R2", 1);          // R2 shortest gap

    // R4: stop before any start is ignored
    cur_req = "R4";
    @(negedge clk) stop_evt = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 no done", done, 0);
    stop_evt = 1'b0;
    repeat (4) @(negedge clk);
    run_gap("R4", 7);

    // R4: start and stop rise together; only the later stop ends the window
    cur_req = "R4";
    @(negedge clk) begin start_evt = 1'b1; stop_evt = 1'b1; end
    repeat (4) @(negedge clk);
    stop_evt = 1'b0;
    repeat (4) @(negedge clk);
    stop_evt = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 same-cycle count", meas_count, 8);
    start_evt = 1'b0; stop_evt = 1'b0;
    repeat (3) @(negedge clk);
    pulse_rearm();

    // R7: restart attempt while open; R6: rearm while open ignored
    cur_req = "R7";
    @(negedge clk) start_evt = 1'b1;
    repeat (2) @(negedge clk);
    rearm = 1'b1;
    @(negedge clk) begin rearm = 1'b0; start_evt = 1'b0; end
    repeat (3) @(negedge clk);
    start_evt = 1'b1;
    repeat (3) @(negedge clk);
    stop_evt = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 count", meas_count, 9);
    start_evt = 1'b0; stop_evt = 1'b0;
    repeat (3) @(negedge clk);

    // R6: without rearm a new interval is ignored
    cur_req = "R6";
    measure(3, lat, res, ovf);
    chk("R6 no done while held", lat, -1);
    chk("R6 result kept", meas_count, 9);
    pulse_rearm();
    run_gap("R6", 4);

    // R5: saturation boundary and overflow
    run_gap("R5", TOP);
    run_gap("R5", TOP + 1);
    run_gap("R5", TOP + 37);
    run_gap("R5", 2);          // overflow cleared by the next measurement

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule